// File: doc/BRIEF.md
# Two-Stage Edge Interrupt Capture

This block gathers completion signals from a set of external flash chips, one interrupt line per chip, and turns them into a single processor interrupt. Each line first passes through a two-flop synchronizer. The block then looks for rising edges only, so a line that stays high or falls sets nothing.

Status is held in two sticky layers. A rising edge on a line sets that chip's *done* flag. Each cycle, every done flag whose chip is unmasked sets the matching *pending* bit. The processor interrupt is the OR of the pending bits. Software has two ways to use the block. It can poll the done flags over the register bus. Or it can take the interrupt and then clear both layers, each with its own write-one-to-clear register.

A small register bus gives access to the block. Writes take effect on the clock edge where `bus_we` is high. Read data is registered, so `bus_rdata` shows the register selected by `bus_addr` one clock later.

Top module: `flash_irq_capture`

## Requirements
- R1: After reset all done flags and pending bits are 0, every mask bit is 1 and `irq` is low.
- R2: A rising edge on `dev_int[x]` sets done flag x. A line held high, or a falling edge, sets nothing. A line held high after its flag was cleared leaves the flag clear.
- R3: Pending bit x is set from done flag x only while mask bit x is 0. A masked chip's done flag leaves pending bit x at 0.
- R4: `irq` is the OR of the pending bits. It goes high on the same clock edge that a pending bit is set.
- R5: A write to the done-clear register (address 1) clears every done flag whose data bit is 1. Data bits of 0 leave their flags unchanged.
- R6: A write to the pending-clear register (address 4) clears every pending bit whose data bit is 1. `irq` falls only when no pending bit remains set.
- R7: A rising edge on a line is detected in the same cycle as a done-clear write to that line's bit. In that case the set wins and the flag stays 1.
- R8: The two layers clear independently. Clearing a done flag leaves its pending bit set, and clearing a pending bit leaves the done flags unchanged.
- R9: The mask register (address 2) can be read and written. Unmasking a chip whose done flag is already set sets its pending bit on the next clock edge.
- R10: The register map is as follows. Address 0 holds the done flags (read-only). Address 1 is done-clear and reads 0. Address 2 is the mask. Address 3 holds the pending bits (read-only). Address 4 is pending-clear and reads 0. Bit x belongs to chip x, and bits at or above the chip count read 0.
- R11: Timing is counted from the first clock edge that samples `dev_int[x]` high. The done flag is set on the third such edge, and the pending bit and `irq` (if unmasked) are set on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_int | input | NCHIP | Per-chip interrupt lines, asynchronous |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data for the previous cycle's address |
| irq | output | 1 | Processor interrupt, registered |

## Verification
A wrong internal state first shows up in one of two ways. `irq` may rise a cycle early or late, or rise at all for a masked chip. Or a value read back at addresses 0, 2 or 3 may differ, one cycle after the address is presented. Edge-detection faults, such as a stuck or level-sensitive detector, show within four edges of a line change as a spurious or missing done flag. Faults in clear ordering, or in the set-over-clear priority, show in the read-back that follows the write.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    SEL_DONE     = 3'd0,
    SEL_DONE_CLR = 3'd1,
    SEL_MASK     = 3'd2,
    SEL_PEND     = 3'd3,
    SEL_PEND_CLR = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int NLINE  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NLINE-1:0] line_in,
  output logic [NLINE-1:0] rise
);
  localparam int DEPTH = STAGES + 1;

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    logic [DEPTH-1:0] chain;

    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[DEPTH-2:0], line_in[g]};
    end

    assign rise[g] = chain[DEPTH-2] & ~chain[DEPTH-1];
  end
endmodule

// File: rtl/irq_sticky_layer.sv
module irq_sticky_layer #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q,
  output logic [N-1:0] q_next
);
  // set has priority over a simultaneous clear
  assign q_next = (q & ~clr_i) | set_i;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_next;
  end
endmodule

// File: rtl/irq_regbus.sv
module irq_regbus
  import flash_irq_pkg::*;
#(
  parameter int N  = 2,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [N-1:0]      done,
  input  logic [N-1:0]      pend,
  output logic [N-1:0]      done_clr,
  output logic [N-1:0]      pend_clr,
  output logic [N-1:0]      mask,
  output logic [DW-1:0]     rdata
);
  reg_sel_e      sel;
  logic [DW-1:0] rd_next;

  assign sel      = reg_sel_e'(addr);
  assign done_clr = (we && sel == SEL_DONE_CLR) ? wdata[N-1:0] : '0;
  assign pend_clr = (we && sel == SEL_PEND_CLR) ? wdata[N-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst)                       mask <= '1;
    else if (we && sel == SEL_MASK) mask <= wdata[N-1:0];
  end

  always_comb begin
    rd_next = '0;
    case (sel)
      SEL_DONE: rd_next[N-1:0] = done;
      SEL_MASK: rd_next[N-1:0] = mask;
      SEL_PEND: rd_next[N-1:0] = pend;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/flash_irq_capture.sv
module flash_irq_capture
  import flash_irq_pkg::*;
#(
  parameter int NCHIP       = 2,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCHIP-1:0]  dev_int,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq
);
  logic [NCHIP-1:0] rise;
  logic [NCHIP-1:0] done, done_next, done_clr;
  logic [NCHIP-1:0] pend, pend_next, pend_clr, pend_set;
  logic [NCHIP-1:0] mask;

  irq_edge_sync #(.NLINE(NCHIP), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .line_in(dev_int), .rise(rise)
  );

  irq_sticky_layer #(.N(NCHIP)) u_done (
    .clk(clk), .rst(rst), .set_i(rise), .clr_i(done_clr),
    .q(done), .q_next(done_next)
  );

  assign pend_set = done & ~mask;

  irq_sticky_layer #(.N(NCHIP)) u_pend (
    .clk(clk), .rst(rst), .set_i(pend_set), .clr_i(pend_clr),
    .q(pend), .q_next(pend_next)
  );

  irq_regbus #(.N(NCHIP), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .done(done), .pend(pend), .done_clr(done_clr), .pend_clr(pend_clr),
    .mask(mask), .rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |pend_next;
  end

  logic unused_ok;
  assign unused_ok = ^done_next;
endmodule

// File: rtl/flash_irq_capture_chk.sv
module flash_irq_capture_chk #(
  parameter int NCHIP = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [NCHIP-1:0] rise,
  input logic [NCHIP-1:0] done,
  input logic [NCHIP-1:0] pend,
  input logic [NCHIP-1:0] mask,
  input logic [NCHIP-1:0] done_clr,
  input logic [NCHIP-1:0] pend_clr,
  input logic             irq
);
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (done == '0 && pend == '0 && mask == '1 && !irq));

  p_rise_sets_done_r2: assert property (@(posedge clk) disable iff (rst)
    (rise != '0) |=> ((done & $past(rise)) == $past(rise)));

  p_mask_gates_r3: assert property (@(posedge clk) disable iff (rst)
    ((done & ~mask) == '0) |=> ((pend & ~$past(pend)) == '0));

  p_irq_is_or_r4: assert property (@(posedge clk) disable iff (rst)
    irq == (|pend));

  p_done_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (done_clr != '0) |=> ((done & $past(done_clr & ~rise)) == '0));

  p_pend_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (pend_clr != '0) |=> ((pend & $past(pend_clr & ~(done & ~mask))) == '0));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    ((rise & done_clr) != '0) |=> ((done & $past(rise & done_clr)) == $past(rise & done_clr)));

  p_layers_apart_r8: assert property (@(posedge clk) disable iff (rst)
    (done_clr != '0 && pend_clr == '0) |=> ((pend & $past(pend)) == $past(pend)));
endmodule

bind flash_irq_capture flash_irq_capture_chk #(.NCHIP(NCHIP)) u_chk (
  .clk(clk), .rst(rst), .rise(rise), .done(done), .pend(pend), .mask(mask),
  .done_clr(done_clr), .pend_clr(pend_clr), .irq(irq)
);

// File: tb/tb_flash_irq_capture.sv
`timescale 1ns/1ps
module tb_flash_irq_capture;
  localparam int NCHIP = 2;
  localparam int DW    = 32;
  localparam logic [2:0] A_DONE = 3'd0, A_DCLR = 3'd1, A_MASK = 3'd2,
                         A_PEND = 3'd3, A_PCLR = 3'd4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCHIP-1:0] dev_int = '0;
  logic bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic irq;
  int n_run = 0;
  int n_fail = 0;
  logic [DW-1:0] rv;

  always #10 clk = ~clk;

  flash_irq_capture #(.NCHIP(NCHIP), .DW(DW)) dut (
    .clk(clk), .rst(rst), .dev_int(dev_int), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic t_reset;
    rd(A_DONE, rv); check("R1 done", rv, 0);
    rd(A_PEND, rv); check("R1 pend", rv, 0);
    rd(A_MASK, rv); check("R1 mask", rv, 3);
    check("R1 irq", DW'(irq), 0);
  endtask

  task automatic t_latency;
    wr(A_MASK, 32'h2);
    @(negedge clk); dev_int[0] = 1'b1;
    cycles(3); check("R11 irq low after 3 edges", DW'(irq), 0);
    cycles(1); check("R11/R4 irq high after 4th edge", DW'(irq), 1);
    rd(A_DONE, rv); check("R2 done0 set", rv, 1);
    rd(A_PEND, rv); check("R3 pend0 set unmasked", rv, 1);
  endtask

  task automatic t_write_zero;
    wr(A_DCLR, 0); rd(A_DONE, rv); check("R5 zero write keeps done", rv, 1);
    wr(A_PCLR, 0); rd(A_PEND, rv); check("R6 zero write keeps pend", rv, 1);
  endtask

  task automatic t_layers;
    wr(A_DCLR, 1);
    rd(A_DONE, rv); check("R5 done0 cleared", rv, 0);
    rd(A_PEND, rv); check("R8 pend0 survives done clear", rv, 1);
    check("R8 irq stays", DW'(irq), 1);
    wr(A_PCLR, 1);
    rd(A_PEND, rv); check("R6 pend0 cleared", rv, 0);
    check("R6 irq low", DW'(irq), 0);
    rd(A_DONE, rv); check("R8 done unchanged by pend clear", rv, 0);
  endtask

  task automatic t_level_and_fall;
    cycles(5); rd(A_DONE, rv); check("R2 held high no set", rv, 0);
    @(negedge clk); dev_int[0] = 1'b0;
    cycles(5); rd(A_DONE, rv); check("R2 falling edge no set", rv, 0);
    check("R2 irq low", DW'(irq), 0);
  endtask

  task automatic t_masked;
    @(negedge clk); dev_int[1] = 1'b1;
    cycles(6);
    rd(A_DONE, rv); check("R2 done1 set", rv, 2);
    rd(A_PEND, rv); check("R3 masked pend1 stays 0", rv, 0);
    check("R3 irq low while masked", DW'(irq), 0);
    wr(A_MASK, 0);
    rd(A_MASK, rv); check("R9 mask reads back", rv, 0);
    rd(A_PEND, rv); check("R9 unmask sets pend1", rv, 2);
    check("R9 irq high", DW'(irq), 1);
    wr(A_DCLR, 2); wr(A_PCLR, 2);
    rd(A_PEND, rv); check("R6 pend1 cleared", rv, 0);
    check("R6 irq low", DW'(irq), 0);
  endtask

  task automatic t_two_pending;
    @(negedge clk); dev_int = 2'b00;
    cycles(4);
    @(negedge clk); dev_int = 2'b11;
    cycles(6);
    rd(A_PEND, rv); check("R4 both pend", rv, 3);
    wr(A_DCLR, 3);
    wr(A_PCLR, 1);
    check("R6 irq held by other bit", DW'(irq), 1);
    wr(A_PCLR, 2);
    check("R6 irq low when none left", DW'(irq), 0);
  endtask

  task automatic t_collision;
    @(negedge clk); dev_int[0] = 1'b0;
    cycles(4);
    rd(A_DONE, rv); check("R7 precondition done clear", rv, 0);
    @(negedge clk); dev_int[0] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = A_DCLR; bus_wdata = 1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
    rd(A_DONE, rv); check("R7 set wins over clear", rv & 1, 1);
  endtask

  task automatic t_map;
    rd(A_DCLR, rv); check("R10 done-clear reads 0", rv, 0);
    rd(A_PCLR, rv); check("R10 pend-clear reads 0", rv, 0);
    wr(A_MASK, 32'hFFFF_FFFF);
    rd(A_MASK, rv); check("R10 upper mask bits read 0", rv, 3);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset;
    t_latency;
    t_write_zero;
    t_layers;
    t_level_and_fall;
    t_masked;
    t_two_pending;
    t_collision;
    t_map;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule